// File: doc/BRIEF.md
# Cascading DMA Channel Arbiter

This block decides which of several DMA request lines gets the system bus and when. Each channel has a request input, a mask bit and a two-bit mode. When at least one unmasked channel is requesting, the arbiter asks its upstream bus owner for the bus. Once the owner answers with a hold acknowledge, the arbiter grants exactly one channel with a one-hot acknowledge. For ordinary channels it also flags that the controller drives the bus for a fixed number of cycles per transfer. For a cascade channel it gives only the acknowledge. The device behind that channel then owns the bus until it withdraws its request.

Selection is by fixed priority, with the lowest channel index winning. The winner is chosen only at tenure boundaries. While further work is pending, the bus request stays high and the next channel follows without a gap. Because a cascade grant simply passes the bus along, two instances can be chained. The secondary's bus request drives channel 0 of the primary. The primary's channel 0 acknowledge becomes the secondary's hold acknowledge, which leaves seven of the eight channels free for peripherals.

Top module: `dma_chan_arbiter`

## Requirements
- R1: `dack` is zero or one-hot at all times, and is never nonzero while `hrq` is low.
- R2: From idle, `hrq` rises one clock after an edge at which some channel has `drq` high with its `ch_mask` bit low. A request whose mask bit is 1 never raises `hrq`.
- R3: No `dack` bit is set before `hlda` is seen high. The grant appears one clock after the first edge at which `hlda` is high while the bus is requested. If no channel is eligible at that edge, `hrq` drops instead.
- R4: Among eligible channels, the one with the lowest index is granted.
- R5: For a non-cascade grant, each transfer lasts XFER_CYCLES clocks with `bus_drive` high throughout. `xfer_last` is high only in the final clock of each transfer.
- R6: Mode 2'b00 (single; 2'b11 behaves the same) makes one transfer per tenure. That channel is excluded from the arbitration at the end of that tenure. If it is the only requester, `hrq` drops for one clock and is then raised again.
- R7: In mode 2'b01 (demand), transfers repeat back to back while the channel's `drq` stays high. The tenure ends after a transfer at whose last clock `drq` is low.
- R8: In mode 2'b10 (cascade), the granted channel gets `dack` only, with `bus_drive` and `xfer_last` low. The grant holds until its `drq` is sampled low, and mask changes during the grant have no effect.
- R9: A request from a higher-priority channel arriving during a tenure does not pre-empt it.
- R10: When a tenure ends and another channel is eligible, that channel's `dack` appears one clock later with `hrq` staying high.
- R11: When a tenure ends with no channel eligible, `hrq` and `dack` are low one clock later.
- R12: Two instances chain correctly. The secondary's `hrq` drives the primary's `drq[0]`, the primary's channel 0 is in cascade mode, and its `dack[0]` drives the secondary's `hlda`. A secondary request then reaches its channel through both levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drq | input | NUM_CH | Per-channel transfer request |
| ch_mask | input | NUM_CH | Per-channel mask; 1 blocks a new grant |
| ch_mode | input | 2*NUM_CH | Per-channel mode, two bits each: 00 single, 01 demand, 10 cascade, 11 single |
| hlda | input | 1 | Hold acknowledge from the upstream bus owner |
| hrq | output | 1 | Bus request to the upstream owner |
| dack | output | NUM_CH | One-hot channel acknowledge |
| bus_drive | output | 1 | High while this controller drives address and strobes |
| xfer_last | output | 1 | High in the last clock of each transfer |

## Verification
Every output comes from a state register, so each response is due exactly one clock after the edge that sampled its cause. The bus request follows an eligible request by one clock, and the grant follows a seen acknowledge by one clock. A transfer end shows on `xfer_last` in clock XFER_CYCLES of that transfer, and the next grant or bus release appears one clock after the tenure-ending edge. For the two-level chain, each level adds one clock in each direction. The bench drives inputs just after a rising edge and checks outputs at that same point after the number of edges these counts give. It never waits for a condition in an open-ended loop.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE  = 2'b00,
      MODE_DEMAND  = 2'b01,
      MODE_CASCADE = 2'b10,
      MODE_RSVD    = 2'b11
   } chmode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_WAIT  = 2'b01,
      ST_SERVE = 2'b10
   } arb_state_e;

   // reserved encoding behaves as single
   function automatic chmode_e decode_mode(input logic [1:0] raw);
      case (raw)
         2'b01:   decode_mode = MODE_DEMAND;
         2'b10:   decode_mode = MODE_CASCADE;
         default: decode_mode = MODE_SINGLE;
      endcase
   endfunction

endpackage

// File: rtl/dmaarb_prio.sv
module dmaarb_prio #(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0] req,
   output logic [NUM_CH-1:0] pick,
   output logic              any
);
   logic [NUM_CH:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
         assign pick[i]   = req[i] & ~seen[i];
         assign seen[i+1] = seen[i] | req[i];
      end
   endgenerate

   assign any = seen[NUM_CH];

   always_comb begin
      // R4
      pick_subset_chk : assert ((pick & ~req) == '0);
      // R1
      pick_onehot_chk : assert ($onehot0(pick));
   end
endmodule

// File: rtl/dmaarb_beat.sv
module dmaarb_beat #(
   parameter int XFER_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);
   localparam int CW = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;
   localparam logic [CW-1:0] TOP = CW'(XFER_CYCLES - 1);

   logic [CW-1:0] cnt;

   generate
      if (XFER_CYCLES < 1) begin : g_bad_len
         $error("XFER_CYCLES must be at least 1");
      end
   endgenerate

   assign last = run && (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || last)   cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   // R5
   beat_limit_chk : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP);
   // R5
   beat_idle_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
   import dmaarb_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int XFER_CYCLES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CH-1:0]     drq,
   input  logic [NUM_CH-1:0]     ch_mask,
   input  logic [2*NUM_CH-1:0]   ch_mode,
   input  logic                  hlda,
   output logic                  hrq,
   output logic [NUM_CH-1:0]     dack,
   output logic                  bus_drive,
   output logic                  xfer_last
);
   localparam int MODE_W = 2;

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("NUM_CH must be at least 2");
      end
   endgenerate

   arb_state_e         state, state_nxt;
   logic [NUM_CH-1:0]  cur_oh, cur_oh_nxt;
   chmode_e            cur_mode, cur_mode_nxt;

   logic [NUM_CH-1:0]  eligible, excl, cand, win_oh;
   logic               win_any, serving, is_casc, is_demand, cur_req;
   logic               beat_last, tenure_end;
   logic [MODE_W-1:0]  win_raw;

   assign eligible  = drq & ~ch_mask;
   assign serving   = (state == ST_SERVE);
   assign is_casc   = (cur_mode == MODE_CASCADE);
   assign is_demand = (cur_mode == MODE_DEMAND);
   assign cur_req   = |(drq & cur_oh);

   dmaarb_beat #(.XFER_CYCLES(XFER_CYCLES)) u_beat (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (serving && !is_casc),
      .last  (beat_last)
   );

   always_comb begin
      if (!serving)     tenure_end = 1'b0;
      else if (is_casc) tenure_end = !cur_req;
      else              tenure_end = beat_last && !(is_demand && cur_req);
   end

   // a single-mode channel must give the bus back before its next transfer
   assign excl = (tenure_end && !is_casc && !is_demand) ? cur_oh : '0;
   assign cand = eligible & ~excl;

   dmaarb_prio #(.NUM_CH(NUM_CH)) u_prio (
      .req  (cand),
      .pick (win_oh),
      .any  (win_any)
   );

   always_comb begin
      win_raw = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (win_oh[i]) win_raw = ch_mode[i*MODE_W +: MODE_W];
      end
   end

   always_comb begin
      state_nxt    = state;
      cur_oh_nxt   = cur_oh;
      cur_mode_nxt = cur_mode;
      case (state)
         ST_IDLE: begin
            if (|eligible) state_nxt = ST_WAIT;
         end
         ST_WAIT: begin
            if (hlda) begin
               if (win_any) begin
                  state_nxt    = ST_SERVE;
                  cur_oh_nxt   = win_oh;
                  cur_mode_nxt = decode_mode(win_raw);
               end else begin
                  state_nxt = ST_IDLE;
               end
            end
         end
         ST_SERVE: begin
            if (tenure_end) begin
               if (win_any && hlda) begin
                  cur_oh_nxt   = win_oh;
                  cur_mode_nxt = decode_mode(win_raw);
               end else begin
                  state_nxt    = ST_IDLE;
                  cur_oh_nxt   = '0;
                  cur_mode_nxt = MODE_SINGLE;
               end
            end
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_oh   <= '0;
         cur_mode <= MODE_SINGLE;
      end else begin
         state    <= state_nxt;
         cur_oh   <= cur_oh_nxt;
         cur_mode <= cur_mode_nxt;
      end
   end

   assign hrq       = (state != ST_IDLE);
   assign dack      = serving ? cur_oh : '0;
   assign bus_drive = serving && !is_casc;
   assign xfer_last = bus_drive && beat_last;

   // R1
   dack_onehot_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack));
   // R1
   dack_needs_hrq_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> hrq);
   // R3
   grant_after_hlda_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|dack) |-> $past(hlda));
   // R2
   idle_quiet_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!hrq && ((drq & ~ch_mask) == '0)) |=> !hrq);
   // R8
   casc_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (serving && is_casc && cur_req) |=> $stable(dack));
   // R8
   casc_no_strobe_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (serving && is_casc) |-> !xfer_last);
endmodule

// File: tb/sim_dma_chan_arbiter.sv
`timescale 1ns/1ps
module sim_dma_chan_arbiter;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   // main instance
   logic [N-1:0]   drq, mask, dack;
   logic [2*N-1:0] mode;
   logic           hlda, hrq, bdrv, xlast;

   dma_chan_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .drq(drq), .ch_mask(mask), .ch_mode(mode),
      .hlda(hlda), .hrq(hrq), .dack(dack), .bus_drive(bdrv), .xfer_last(xlast));

   // two-level chain: u1 secondary, u2 primary
   logic [N-1:0] s_drq, s_dack, p_dack;
   logic         s_hrq, s_bdrv, s_xlast, p_hrq, p_bdrv, p_xlast;

   dma_chan_arbiter u1 (
      .clk(clk), .rst_n(rst_n), .drq(s_drq), .ch_mask(4'b0000), .ch_mode(8'h00),
      .hlda(p_dack[0]), .hrq(s_hrq), .dack(s_dack), .bus_drive(s_bdrv),
      .xfer_last(s_xlast));

   dma_chan_arbiter u2 (
      .clk(clk), .rst_n(rst_n), .drq({3'b000, s_hrq}), .ch_mask(4'b0000),
      .ch_mode(8'b00_00_00_10), .hlda(1'b1), .hrq(p_hrq), .dack(p_dack),
      .bus_drive(p_bdrv), .xfer_last(p_xlast));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic drain();
      for (int i = 0; i < 12; i++) begin
         if (!hrq && dack == '0) break;
         tick();
      end
      check(!hrq && dack == '0, "R11 drain", {hrq, dack}, 0);
   endtask

   function automatic logic [N-1:0] low_bit(input logic [N-1:0] v);
      return v & (~v + 1'b1);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000 && !done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      drq = '0; mask = '0; mode = '0; hlda = 1'b0; s_drq = '0;
      tick(3);
      rst_n = 1'b1;
      tick();
      check(!hrq && dack == '0 && !bdrv && !xlast, "R1 reset", {hrq, dack, bdrv, xlast}, 0);

      // masked request, then hold-acknowledge handshake
      drq = 4'b0010; mask = 4'b0010;
      tick(3);
      check(!hrq, "R2 masked", hrq, 0);
      mask = '0;
      tick();
      check(hrq && dack == '0, "R2 raise", {hrq, dack}, 5'h10);
      tick(2);
      check(dack == '0, "R3 no hlda", dack, 0);
      hlda = 1'b1;
      tick();
      check(dack == 4'b0010 && bdrv && !xlast, "R3 grant", {dack, bdrv, xlast}, 6'b001010);
      tick();
      check(bdrv && xlast, "R5 last beat", {bdrv, xlast}, 3);
      tick();
      check(!hrq && dack == '0 && !bdrv, "R6 release", {hrq, dack, bdrv}, 0);
      tick();
      check(hrq && dack == '0, "R6 reacquire", {hrq, dack}, 5'h10);
      tick();
      check(dack == 4'b0010, "R6 regrant", dack, 4'b0010);
      drq = '0;
      drain();

      // priority sweep over request and mask patterns
      for (int p = 0; p < 16; p++) begin
         for (int m = 0; m < 16; m++) begin
            logic [N-1:0] e;
            drq = p[N-1:0]; mask = m[N-1:0];
            e = drq & ~mask;
            tick();
            check(hrq == (e != 0), "R2 sweep", hrq, (e != 0));
            tick();
            if (e != 0)
               check(dack == low_bit(e), "R4 sweep", dack, low_bit(e));
            else
               check(!hrq && dack == '0, "R2 sweep quiet", {hrq, dack}, 0);
            drq = '0; mask = '0;
            drain();
         end
      end

      // demand mode on ch2, ch0 arrives mid-tenure
      mode = 8'b00_01_00_00;
      drq = 4'b0100;
      tick(2);
      check(dack == 4'b0100 && bdrv, "R7 demand grant", {dack, bdrv}, 5'b01001);
      tick();
      check(xlast, "R5 demand beat", xlast, 1);
      drq = 4'b0101;
      tick();
      check(dack == 4'b0100 && bdrv && !xlast, "R9 no preempt", {dack, bdrv, xlast}, 6'b010010);
      tick();
      check(xlast && dack == 4'b0100, "R7 second beat", {dack, xlast}, 5'b01001);
      tick();
      check(dack == 4'b0100 && bdrv, "R7 continue", {dack, bdrv}, 5'b01001);
      tick();
      check(xlast, "R7 third beat", xlast, 1);
      drq = 4'b0001;
      tick();
      check(hrq && dack == 4'b0001 && bdrv && !xlast, "R10 back to back",
            {hrq, dack, bdrv, xlast}, 7'b1000110);
      drq = '0;
      drain();

      // cascade on ch3
      mode = 8'b10_00_00_00;
      drq = 4'b1000;
      tick(2);
      check(dack == 4'b1000 && !bdrv, "R8 cascade grant", {dack, bdrv}, 5'b10000);
      for (int i = 0; i < 8; i++) begin
         if (i == 2) mask = 4'b1000;
         if (i == 4) drq = 4'b1010;
         tick();
         check(dack == 4'b1000 && !bdrv && !xlast, "R8 cascade hold",
               {dack, bdrv, xlast}, 6'b100000);
      end
      drq = 4'b0010;
      tick();
      check(hrq && dack == 4'b0010 && bdrv, "R10 after cascade", {hrq, dack, bdrv}, 6'b100101);
      drq = '0; mask = '0;
      drain();
      drq = 4'b1000;
      tick(3);
      check(dack == 4'b1000, "R8 cascade again", dack, 4'b1000);
      drq = '0;
      tick();
      check(!hrq && dack == '0, "R11 cascade release", {hrq, dack}, 0);

      // two-level chain
      s_drq = 4'b0100;
      tick();
      check(s_hrq && !p_hrq, "R12 secondary hrq", {s_hrq, p_hrq}, 2'b10);
      tick();
      check(p_hrq && p_dack == '0, "R12 primary hrq", {p_hrq, p_dack}, 5'h10);
      tick();
      check(p_dack == 4'b0001 && !p_bdrv && s_dack == '0, "R12 primary cascade",
            {p_dack, p_bdrv, s_dack}, 9'b000100000);
      tick();
      check(s_dack == 4'b0100 && s_bdrv, "R12 secondary grant", {s_dack, s_bdrv}, 5'b01001);
      s_drq = '0;
      tick();
      check(s_xlast, "R12 secondary beat", s_xlast, 1);
      tick();
      check(!s_hrq && p_dack == 4'b0001, "R12 secondary release", {s_hrq, p_dack}, 5'b00001);
      tick();
      check(!p_hrq && p_dack == '0, "R12 primary release", {p_hrq, p_dack}, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule